// File: doc/BRIEF.md
# Masked Packed-Lane AND Unit

This block forms the bitwise AND of 64-bit lanes across a 512-bit vector datapath. It accepts two source vectors, the prior value of the destination vector, an 8-bit per-lane write mask, a zeroing select, a broadcast select and a 3-bit form code. The form code sets the active vector length and also selects how the result is formed. It chooses among a legacy 128-bit form, two unmasked forms (128 and 256 bits) and three masked forms (128, 256 and 512 bits).

The result is captured in an output register one clock after an input strobe, and a single-cycle valid pulse marks it. The legacy form keeps every destination bit above bit 127. The unmasked and masked forms clear every bit above the active length. In the masked forms each active lane either takes the AND, is cleared, or keeps its old value. The broadcast select replicates lane 0 of the second source across all active lanes. Upstream decode asserts it only for the memory-operand variant. Lane data is treated as raw bits.

Top module: `simd_and_mask_unit`

## Requirements
- R1: A synchronous active-high reset clears `dst_new` to all zeros and drives `out_valid` low.
- R2: When `in_valid` is high with a supported form code, `dst_new` updates and `out_valid` is high after the next rising edge. `out_valid` is high for one cycle only. While `in_valid` is low, `dst_new` holds its value.
- R3: The active lane count is 2 for codes 0, 1 and 3, 4 for codes 2 and 4, and 8 for code 5. Lane n occupies bits [64n+63:64n].
- R4: Legacy form (code 0): lanes 0 and 1 become `dst_old & src_b`, and bits 511:128 keep their `dst_old` value. `src_a`, `lane_mask`, `zero_sel` and `bcast_sel` have no effect.
- R5: Unmasked forms (code 1 = 128 bits, code 2 = 256 bits): each active lane is `src_a & src_b`, and all bits above the active length are zero. `lane_mask`, `zero_sel` and `bcast_sel` have no effect.
- R6: Masked forms (code 3 = 128, code 4 = 256, code 5 = 512 bits): an active lane whose `lane_mask` bit is 1 receives `src_a & src_b`.
- R7: In a masked form, an active lane whose mask bit is 0 becomes zero when `zero_sel` is 1, and otherwise keeps its `dst_old` value.
- R8: In a masked form with `bcast_sel` = 1, lane 0 of `src_b` is the second operand for every active lane with its mask bit set.
- R9: In a masked form, all bits above the active length are zero, and mask bits for lanes at or above the active count have no effect.
- R10: Form codes 6 and 7 are unsupported. A strobe with either code leaves `dst_new` unchanged and raises no `out_valid` pulse.
- R11: Lane data is raw bits. NaN and denormal encodings are ANDed bit for bit, with no substitution or flagging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| form_sel | input | 3 | Form code (0 legacy, 1-2 unmasked, 3-5 masked) |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| dst_old | input | 512 | Prior destination value |
| lane_mask | input | 8 | Per-lane write mask, bit n for lane n |
| zero_sel | input | 1 | 1 = clear unmasked lanes, 0 = merge |
| bcast_sel | input | 1 | 1 = broadcast lane 0 of src_b |
| out_valid | output | 1 | One-cycle result-valid pulse |
| dst_new | output | 512 | Registered new destination value |

## Verification
The three source vectors carry a distinct pseudo-random value in every lane. This means a lane that wrongly copies from a neighbour, takes the wrong operand, or skips the AND gives a different value. Mask patterns mix set and clear bits inside the active range and add stray bits above it, so merge, zeroing and length clearing are each exposed separately. Broadcast runs compare lane 0 replication against per-lane operands. All-ones operands paired with NaN and denormal encodings confirm the bitwise treatment. Codes 6 and 7 are sent after a known result so that a spurious update or pulse shows up.

// File: rtl/simd_and_pkg.sv
`timescale 1ns/1ps
package simd_and_pkg;

  typedef enum logic [2:0] {
    FORM_LEG128   = 3'd0,
    FORM_PLAIN128 = 3'd1,
    FORM_PLAIN256 = 3'd2,
    FORM_MASK128  = 3'd3,
    FORM_MASK256  = 3'd4,
    FORM_MASK512  = 3'd5
  } form_e;

  typedef struct packed {
    logic ok;
    logic legacy;
    logic masked;
  } form_ctl_t;

endpackage

// File: rtl/simd_and_form_dec.sv
`timescale 1ns/1ps
module simd_and_form_dec
  import simd_and_pkg::*;
#(
  parameter int LANES = 8,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic [2:0]       form_sel,
  output form_ctl_t        ctl,
  output logic [CNT_W-1:0] lane_cnt
);

  localparam logic [CNT_W-1:0] CNT_128 = CNT_W'(2);
  localparam logic [CNT_W-1:0] CNT_256 = CNT_W'(4);
  localparam logic [CNT_W-1:0] CNT_512 = CNT_W'(LANES);

  always_comb begin
    ctl      = '0;
    lane_cnt = '0;
    case (form_e'(form_sel))
      FORM_LEG128: begin
        ctl.ok = 1'b1; ctl.legacy = 1'b1; lane_cnt = CNT_128;
      end
      FORM_PLAIN128: begin
        ctl.ok = 1'b1; lane_cnt = CNT_128;
      end
      FORM_PLAIN256: begin
        ctl.ok = 1'b1; lane_cnt = CNT_256;
      end
      FORM_MASK128: begin
        ctl.ok = 1'b1; ctl.masked = 1'b1; lane_cnt = CNT_128;
      end
      FORM_MASK256: begin
        ctl.ok = 1'b1; ctl.masked = 1'b1; lane_cnt = CNT_256;
      end
      FORM_MASK512: begin
        ctl.ok = 1'b1; ctl.masked = 1'b1; lane_cnt = CNT_512;
      end
      default: begin
        ctl      = '0;
        lane_cnt = '0;
      end
    endcase
  end

endmodule

// File: rtl/simd_and_lane.sv
`timescale 1ns/1ps
module simd_and_lane #(
  parameter int LANE_W = 64
) (
  input  logic              active,
  input  logic              legacy,
  input  logic              masked,
  input  logic              mask_bit,
  input  logic              zero_sel,
  input  logic              bcast_sel,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [LANE_W-1:0] b_first,
  input  logic [LANE_W-1:0] d,
  output logic [LANE_W-1:0] res
);

  logic [LANE_W-1:0] b_pick;

  always_comb begin
    b_pick = (masked && bcast_sel) ? b_first : b;
    if (!active) begin
      res = legacy ? d : '0;
    end else if (legacy) begin
      res = d & b;
    end else if (!masked) begin
      res = a & b;
    end else if (mask_bit) begin
      res = a & b_pick;
    end else if (zero_sel) begin
      res = '0;
    end else begin
      res = d;
    end
  end

endmodule

// File: rtl/simd_and_out_reg.sv
`timescale 1ns/1ps
module simd_and_out_reg #(
  parameter int W = 512
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         vld
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      vld <= load;
      if (load) q <= d;
    end
  end

  p_idle_no_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    !load |=> !vld);

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

endmodule

// File: rtl/simd_and_mask_unit.sv
`timescale 1ns/1ps
module simd_and_mask_unit
  import simd_and_pkg::*;
#(
  parameter int LANE_W = 64,
  parameter int LANES  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [2:0]              form_sel,
  input  logic [LANE_W*LANES-1:0] src_a,
  input  logic [LANE_W*LANES-1:0] src_b,
  input  logic [LANE_W*LANES-1:0] dst_old,
  input  logic [LANES-1:0]        lane_mask,
  input  logic                    zero_sel,
  input  logic                    bcast_sel,
  output logic                    out_valid,
  output logic [LANE_W*LANES-1:0] dst_new
);

  localparam int VEC_W  = LANE_W * LANES;
  localparam int LEG_W  = 2 * LANE_W;
  localparam int HALF_W = 4 * LANE_W;
  localparam int CNT_W  = $clog2(LANES + 1);

  form_ctl_t        ctl;
  logic [CNT_W-1:0] lane_cnt;
  logic [VEC_W-1:0] res_vec;

  simd_and_form_dec #(.LANES(LANES), .CNT_W(CNT_W)) u_dec (
    .form_sel (form_sel),
    .ctl      (ctl),
    .lane_cnt (lane_cnt)
  );

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic act;
    assign act = (CNT_W'(n) < lane_cnt);

    simd_and_lane #(.LANE_W(LANE_W)) u_lane (
      .active    (act),
      .legacy    (ctl.legacy),
      .masked    (ctl.masked),
      .mask_bit  (lane_mask[n]),
      .zero_sel  (zero_sel),
      .bcast_sel (bcast_sel),
      .a         (src_a[n*LANE_W +: LANE_W]),
      .b         (src_b[n*LANE_W +: LANE_W]),
      .b_first   (src_b[LANE_W-1:0]),
      .d         (dst_old[n*LANE_W +: LANE_W]),
      .res       (res_vec[n*LANE_W +: LANE_W])
    );
  end

  simd_and_out_reg #(.W(VEC_W)) u_out (
    .clk  (clk),
    .rst  (rst),
    .load (in_valid && ctl.ok),
    .d    (res_vec),
    .q    (dst_new),
    .vld  (out_valid)
  );

  p_valid_next_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && ctl.ok) |=> out_valid);

  p_bad_form_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !ctl.ok) |=> (!out_valid && $stable(dst_new)));

  p_legacy_upper_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == 3'd0) |=>
      (dst_new[VEC_W-1:LEG_W] == $past(dst_old[VEC_W-1:LEG_W])));

  p_short_upper_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (form_sel == 3'd1 || form_sel == 3'd3)) |=>
      (dst_new[VEC_W-1:LEG_W] == '0));

  p_plain256_and_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && form_sel == 3'd2) |=>
      (dst_new[HALF_W-1:0] == $past(src_a[HALF_W-1:0] & src_b[HALF_W-1:0])
       && dst_new[VEC_W-1:HALF_W] == '0));

endmodule

// File: tb/test_simd_and_mask_unit.sv
`timescale 1ns/1ps
module test_simd_and_mask_unit;

  localparam int LW = 64;
  localparam int NL = 8;
  localparam int VW = LW * NL;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    form_sel = '0;
  logic [VW-1:0] src_a = '0, src_b = '0, dst_old = '0;
  logic [NL-1:0] lane_mask = '0;
  logic          zero_sel = 1'b0, bcast_sel = 1'b0;
  logic          out_valid;
  logic [VW-1:0] dst_new;

  int  n_run = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  simd_and_mask_unit i_simd_and_mask_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .form_sel(form_sel),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old), .lane_mask(lane_mask),
    .zero_sel(zero_sel), .bcast_sel(bcast_sel),
    .out_valid(out_valid), .dst_new(dst_new)
  );

  typedef struct packed {
    logic [2:0] form;
    logic [7:0] mask;
    logic       zero;
    logic       bcast;
    logic [7:0] seed;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 8'hff, 1'b1, 1'b1, 8'h01},
    '{3'd0, 8'h00, 1'b0, 1'b0, 8'h02},
    '{3'd1, 8'h00, 1'b1, 1'b1, 8'h03},
    '{3'd2, 8'h5a, 1'b0, 1'b1, 8'h04},
    '{3'd3, 8'h03, 1'b0, 1'b0, 8'h05},
    '{3'd3, 8'hfc, 1'b0, 1'b0, 8'h06},
    '{3'd3, 8'hfe, 1'b1, 1'b0, 8'h07},
    '{3'd4, 8'h0a, 1'b1, 1'b0, 8'h08},
    '{3'd4, 8'hfa, 1'b0, 1'b0, 8'h09},
    '{3'd5, 8'hff, 1'b0, 1'b0, 8'h0a},
    '{3'd5, 8'ha5, 1'b1, 1'b0, 8'h0b},
    '{3'd5, 8'h3c, 1'b0, 1'b1, 8'h0c},
    '{3'd4, 8'h0f, 1'b1, 1'b1, 8'h0d},
    '{3'd3, 8'h01, 1'b0, 1'b1, 8'h0e}
  };

  function automatic logic [VW-1:0] pat(input int s);
    logic [VW-1:0] v;
    for (int n = 0; n < NL; n++)
      v[n*LW +: LW] = (64'h9E3779B97F4A7C15 * 64'(s * 8 + n + 1)) ^ {32'(s), 32'(n)};
    return v;
  endfunction

  // Reference built from the requirement text
  function automatic logic [VW-1:0] model(input logic [2:0] f, input logic [VW-1:0] a,
      input logic [VW-1:0] b, input logic [VW-1:0] d, input logic [7:0] m,
      input logic z, input logic bc);
    logic [VW-1:0] r;
    logic [VW-1:0] bb;
    int cnt;
    r = '0;
    case (f)
      3'd0: begin r = d; r[127:0] = d[127:0] & b[127:0]; end
      3'd1: r[127:0] = a[127:0] & b[127:0];
      3'd2: r[255:0] = a[255:0] & b[255:0];
      default: begin
        cnt = (f == 3'd3) ? 2 : (f == 3'd4) ? 4 : 8;
        bb  = bc ? {NL{b[LW-1:0]}} : b;
        for (int n = 0; n < cnt; n++) begin
          if (m[n])  r[n*LW +: LW] = a[n*LW +: LW] & bb[n*LW +: LW];
          else if (!z) r[n*LW +: LW] = d[n*LW +: LW];
        end
      end
    endcase
    return r;
  endfunction

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] f, input logic [VW-1:0] a, input logic [VW-1:0] b,
      input logic [VW-1:0] d, input logic [7:0] m, input logic z, input logic bc);
    @(negedge clk);
    form_sel = f; src_a = a; src_b = b; dst_old = d;
    lane_mask = m; zero_sel = z; bcast_sel = bc; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] held;
    logic [VW-1:0] ones;
    logic [VW-1:0] nanv;
    ones = '1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset dst_new", dst_new, '0);
    chk("R1 reset out_valid", VW'(out_valid), '0);
    rst = 1'b0;

    // Table walk: R2 R3 R4 R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] a, b, d;
      string tag;
      a = pat(VECS[i].seed * 3);
      b = pat(VECS[i].seed * 3 + 1);
      d = pat(VECS[i].seed * 3 + 2);
      apply(VECS[i].form, a, b, d, VECS[i].mask, VECS[i].zero, VECS[i].bcast);
      if (VECS[i].form == 3'd0) tag = "R3 R4 legacy";
      else if (VECS[i].form <= 3'd2) tag = "R3 R5 unmasked";
      else tag = "R3 R6 R7 R8 R9 masked";
      chk(tag, dst_new, model(VECS[i].form, a, b, d, VECS[i].mask, VECS[i].zero, VECS[i].bcast));
      chk("R2 valid pulse", VW'(out_valid), VW'(1));
    end

    // R2: pulse lasts one cycle, output held while idle
    held = dst_new;
    @(negedge clk);
    chk("R2 pulse ends", VW'(out_valid), '0);
    chk("R2 idle hold", dst_new, held);

    // R3: lane count of the 256-bit unmasked form with all-ones operands
    apply(3'd2, ones, ones, ones, 8'h00, 1'b0, 1'b0);
    chk("R3 256-bit lane count", dst_new, {{(VW-256){1'b0}}, {256{1'b1}}});

    // R10: unsupported codes 6 and 7
    held = dst_new;
    apply(3'd6, pat(90), pat(91), pat(92), 8'hff, 1'b0, 1'b0);
    chk("R10 code 6 no update", dst_new, held);
    chk("R10 code 6 no pulse", VW'(out_valid), '0);
    apply(3'd7, pat(93), pat(94), pat(95), 8'hff, 1'b1, 1'b1);
    chk("R10 code 7 no update", dst_new, held);
    chk("R10 code 7 no pulse", VW'(out_valid), '0);

    // R11: NaN and denormal bits pass unchanged through AND with all ones
    nanv = {NL{64'h7FF8_0000_0000_0001}};
    nanv[LW +: LW] = 64'h0000_0000_0000_0001;
    nanv[2*LW +: LW] = 64'hFFF0_0000_0000_0000;
    apply(3'd5, nanv, ones, '0, 8'hff, 1'b0, 1'b0);
    chk("R11 raw NaN/denormal bits", dst_new, nanv);

    // R1: reset in mid-run clears the output
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset dst_new", dst_new, '0);
    chk("R1 mid-run reset out_valid", VW'(out_valid), '0);
    rst = 1'b0;

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule